// File: doc/BRIEF.md
# Edit-Mode Configuration Array Target

This block models the device side of a small programmable logic part while it sits in its programming mode. It gives a programming sequencer in a testbench something real to talk to. A 6-bit row address picks one of several storage rows. A direction input selects write or read. A serial clock and a serial data line move bits through one internal shift register, and an active-low strobe commits the register to a row or fetches a row into it. All pins are sampled on a free-running system clock, so the model is synchronous and synthesizable.

The rows have mixed widths. There are thirty-two 64-bit fuse rows at addresses 0 to 31 and a 64-bit signature row at 32. The 82-bit architecture control word is at 60 and a one-bit security flag is at 61. A write-mode strobe at address 63 erases the whole array. Every other address is reserved. The block measures each strobe low time in system clock cycles. A write pulse that is too short is rejected and flagged.

Top module: `cfg_array_target`

## Requirements
- R1: After reset `sdout_o` and `short_pulse_o` are 0, and reading any row returns all zeros.
- R2: Each rising edge of `sclk_i` shifts the shift register one place toward bit 0 and puts `sdin_i` into the top bit of the addressed row's width (82 for address 60, 1 for address 61, 64 otherwise). The first bit shifted in therefore ends up as row bit 0.
- R3: With `prog_i` high, a strobe low pulse of at least `MIN_PULSE` clock cycles stores the shift register into fuse row `row_addr_i` (0..31).
- R4: With `prog_i` low, a strobe pulse of any width loads the addressed row into the shift register. `sdout_o` then shows row bit 0, and after each following rising `sclk_i` edge it shows the next higher bit.
- R5: Address 32 holds a 64-bit signature row that is independent of the fuse rows.
- R6: Address 60 holds an 82-bit row, and all 82 bits read back.
- R7: Writes to reserved addresses (33..59, 62) change no row, and reads of them return zeros.
- R8: Writing address 61 stores shift register bit 0 as the security flag, and reading 61 returns it. While the flag is set, fuse rows read as zeros. The signature row and address 60 stay readable.
- R9: A compliant write-mode strobe at address 63 clears every fuse row, the signature row, address 60 and the security flag.
- R10: The strobe low time is counted in system clock cycles. A write pulse shorter than `MIN_PULSE` stores nothing and sets `short_pulse_o`. A compliant write pulse clears it, and read pulses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_addr_i | input | 6 | Row address |
| prog_i | input | 1 | 1 = write, 0 = read |
| sclk_i | input | 1 | Serial shift clock, acts on its rising edge |
| sdin_i | input | 1 | Serial data in |
| strobe_ni | input | 1 | Active-low strobe; the action happens when the pulse ends |
| sdout_o | output | 1 | Shift register bit 0 |
| short_pulse_o | output | 1 | The last write pulse was shorter than the minimum |

## Verification
The row store, the security flag and the pulse counter can only be seen through a later readback, so a corrupt row shows up as a wrong bit pattern on `sdout_o` during the next read of that address. A shifting fault shows within one serial clock of the bad bit, because every bit is compared position by position against the pattern that was written. A miscounted pulse width shows on `short_pulse_o` a few cycles after the strobe is released, and also as a row that was or was not updated. The bench probes this at exactly `MIN_PULSE-1` and `MIN_PULSE` cycles.

// File: rtl/cfg_array_pkg.sv
package cfg_array_pkg;
  localparam int ADDR_W     = 6;
  localparam int FUSE_ROWS  = 32;
  localparam int ROW_W      = 64;
  localparam int CTRL_W     = 82;
  localparam int SR_W       = CTRL_W;
  localparam int SR_IDX_W   = $clog2(SR_W);
  localparam int FUSE_IDX_W = $clog2(FUSE_ROWS);
  localparam int SIG_ADDR   = 32;
  localparam int CTRL_ADDR  = 60;
  localparam int SEC_ADDR   = 61;
  localparam int ERASE_ADDR = 63;

  typedef enum logic [2:0] {
    K_FUSE, K_SIG, K_CTRL, K_SEC, K_ERASE, K_RSVD
  } row_kind_e;

  function automatic row_kind_e decode_row(logic [ADDR_W-1:0] a);
    if (int'(a) < FUSE_ROWS)  return K_FUSE;
    if (int'(a) == SIG_ADDR)  return K_SIG;
    if (int'(a) == CTRL_ADDR) return K_CTRL;
    if (int'(a) == SEC_ADDR)  return K_SEC;
    if (int'(a) == ERASE_ADDR) return K_ERASE;
    return K_RSVD;
  endfunction

  // insertion index = row width - 1
  function automatic logic [SR_IDX_W-1:0] top_bit(row_kind_e k);
    case (k)
      K_CTRL:  return SR_IDX_W'(CTRL_W - 1);
      K_SEC:   return '0;
      default: return SR_IDX_W'(ROW_W - 1);
    endcase
  endfunction
endpackage

// File: rtl/cfg_pulse_timer.sv
module cfg_pulse_timer #(
  parameter int CNT_W     = 16,
  parameter int MIN_PULSE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_ni,
  output logic end_o,
  output logic short_o
);
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall    = !stb_ni && prev_q;
  assign end_o   = stb_ni && !prev_q;
  assign short_o = cnt_q < CNT_W'(MIN_PULSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= stb_ni;
      if (fall)                          cnt_q <= CNT_W'(1);
      else if (!stb_ni && (&cnt_q) == 1'b0) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r10_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_ni && !prev_q) |-> (cnt_q != '0));
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
  import cfg_array_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                sdin_i,
  input  logic [SR_IDX_W-1:0] top_i,
  input  logic                load_i,
  input  logic [SR_W-1:0]     load_data_i,
  output logic [SR_W-1:0]     sr_o
);
  logic [SR_W-1:0] sr_q, shifted;

  always_comb begin
    shifted = sr_q >> 1;
    shifted[top_i] = sdin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_data_i;
    else if (shift_i) sr_q <= shifted;
  end

  assign sr_o = sr_q;

  a_r2_lsb_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i && top_i != '0) |=> (sr_q[0] == $past(sr_q[1])));
endmodule

// File: rtl/cfg_row_store.sv
module cfg_row_store
  import cfg_array_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [SR_W-1:0]   wr_data_i,
  output logic [SR_W-1:0]   rd_data_o
);
  logic [ROW_W-1:0]      fuse_q [FUSE_ROWS];
  logic [ROW_W-1:0]      sig_q;
  logic [CTRL_W-1:0]     ctrl_q;
  logic                  sec_q;
  row_kind_e             kind;
  logic [FUSE_IDX_W-1:0] idx;

  assign kind = decode_row(addr_i);
  assign idx  = addr_i[FUSE_IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FUSE_ROWS; i++) fuse_q[i] <= '0;
      sig_q  <= '0;
      ctrl_q <= '0;
      sec_q  <= 1'b0;
    end else if (wr_i) begin
      case (kind)
        K_FUSE: fuse_q[idx] <= wr_data_i[ROW_W-1:0];
        K_SIG:  sig_q       <= wr_data_i[ROW_W-1:0];
        K_CTRL: ctrl_q      <= wr_data_i[CTRL_W-1:0];
        K_SEC:  sec_q       <= wr_data_i[0];
        K_ERASE: begin
          for (int i = 0; i < FUSE_ROWS; i++) fuse_q[i] <= '0;
          sig_q  <= '0;
          ctrl_q <= '0;
          sec_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (kind)
      K_FUSE: if (!sec_q) rd_data_o[ROW_W-1:0] = fuse_q[idx];
      K_SIG:  rd_data_o[ROW_W-1:0]  = sig_q;
      K_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_q;
      K_SEC:  rd_data_o[0]          = sec_q;
      default: ;
    endcase
  end

  a_r7_rsvd_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind == K_RSVD) |=> ($stable(sig_q) && $stable(ctrl_q) && $stable(sec_q)));
  a_r9_erase_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind == K_ERASE) |=> (!sec_q && ctrl_q == '0 && sig_q == '0));
endmodule

// File: rtl/cfg_array_target.sv
module cfg_array_target
  import cfg_array_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_PULSE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] row_addr_i,
  input  logic              prog_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              strobe_ni,
  output logic              sdout_o,
  output logic              short_pulse_o
);
  logic              sclk_d, sclk_q, sdin_d, prog_d, stb_d;
  logic [ADDR_W-1:0] addr_d;
  logic              pulse_end, pulse_short, wr_ev, rd_ev, viol_q;
  logic [SR_W-1:0]   sr, rd_data;
  row_kind_e         kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      sclk_q <= 1'b0;
      sdin_d <= 1'b0;
      prog_d <= 1'b0;
      stb_d  <= 1'b1;
      addr_d <= '0;
    end else begin
      sclk_d <= sclk_i;
      sclk_q <= sclk_d;
      sdin_d <= sdin_i;
      prog_d <= prog_i;
      stb_d  <= strobe_ni;
      addr_d <= row_addr_i;
    end
  end

  assign kind = decode_row(addr_d);

  cfg_pulse_timer #(.CNT_W(CNT_W), .MIN_PULSE(MIN_PULSE)) u_timer (
    .clk_i, .rst_ni, .stb_ni(stb_d), .end_o(pulse_end), .short_o(pulse_short)
  );

  assign wr_ev = pulse_end && prog_d && !pulse_short;
  assign rd_ev = pulse_end && !prog_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  viol_q <= 1'b0;
    else if (pulse_end && prog_d) viol_q <= pulse_short;
  end

  cfg_shift_reg u_sr (
    .clk_i, .rst_ni,
    .shift_i(sclk_d && !sclk_q), .sdin_i(sdin_d), .top_i(top_bit(kind)),
    .load_i(rd_ev), .load_data_i(rd_data), .sr_o(sr)
  );

  cfg_row_store u_store (
    .clk_i, .rst_ni, .addr_i(addr_d), .wr_i(wr_ev), .wr_data_i(sr), .rd_data_o(rd_data)
  );

  assign sdout_o       = sr[0];
  assign short_pulse_o = viol_q;

  a_r7_rsvd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ev && kind == K_RSVD) |=> (sr == '0));
  a_r10_short_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_end && prog_d && pulse_short) |=> short_pulse_o);
endmodule

// File: tb/cfg_array_target_tb_top.sv
module cfg_array_target_tb_top;
  localparam int MIN_PULSE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic prog = 1'b0, sclk = 1'b0, sdin = 1'b0, stb_n = 1'b1;
  logic sdout, short_pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [81:0] exp_q[$], act_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cfg_array_target #(.MIN_PULSE(MIN_PULSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .row_addr_i(addr), .prog_i(prog), .sclk_i(sclk),
    .sdin_i(sdin), .strobe_ni(stb_n), .sdout_o(sdout), .short_pulse_o(short_pulse)
  );

  function automatic int width_of(int a);
    if (a == 60) return 82;
    if (a == 61) return 1;
    return 64;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [81:0] act, logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
  end

  task automatic sclk_pulse();
    sclk = 1'b1; wait_clk(3);
    sclk = 1'b0; wait_clk(3);
  endtask

  task automatic strobe(int n);
    stb_n = 1'b0; wait_clk(n);
    stb_n = 1'b1; wait_clk(4);
  endtask

  task automatic write_row(int a, logic [81:0] d, int n);
    addr = 6'(a); prog = 1'b1; wait_clk(3);
    for (int i = 0; i < width_of(a); i++) begin
      sdin = d[i];
      sclk_pulse();
    end
    sdin = 1'b0;
    strobe(n);
    prog = 1'b0;
  endtask

  task automatic read_row(int a, logic [81:0] exp, string tag);
    logic [81:0] got = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = 6'(a); prog = 1'b0; wait_clk(3);
    strobe(3);
    for (int i = 0; i < width_of(a); i++) begin
      got[i] = sdout;
      sclk_pulse();
    end
    act_q.push_back(got);
    wait_clk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [81:0] pa = 82'h0_A5C3_0F1E_9876_5432;
    logic [81:0] pb = 82'h0_8000_0000_0000_0001;
    logic [81:0] ps = 82'h0_DEAD_BEEF_0BAD_F00D;
    logic [81:0] pc = 82'h2_5A5A_1234_5678_9ABC_DEF1;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check("R1 sdout", 82'(sdout), 82'd0);
    check("R1 short_pulse", 82'(short_pulse), 82'd0);
    read_row(5, '0, "R1 fuse row 5 after reset");
    read_row(60, '0, "R1 ctrl row after reset");

    // R2 R3 R4 fuse rows
    write_row(3, pa, MIN_PULSE + 2);
    write_row(31, pb, MIN_PULSE);
    check("R10 compliant pulse flag", 82'(short_pulse), 82'd0);
    read_row(3, pa, "R3 R2 fuse row 3");
    read_row(31, pb, "R4 fuse row 31 bit order");
    read_row(0, '0, "R3 untouched row 0");

    // R5 signature
    write_row(32, ps, MIN_PULSE);
    read_row(32, ps, "R5 signature row");
    read_row(3, pa, "R5 fuse row 3 unaffected");

    // R6 wide row
    write_row(60, pc, MIN_PULSE);
    read_row(60, pc, "R6 82-bit row");

    // R7 reserved
    write_row(40, pa, MIN_PULSE);
    read_row(40, '0, "R7 reserved 40 reads zero");
    write_row(62, pb, MIN_PULSE);
    read_row(62, '0, "R7 reserved 62 reads zero");
    read_row(32, ps, "R7 signature unchanged");
    read_row(60, pc, "R7 ctrl unchanged");

    // R10 pulse width boundary
    write_row(7, pa, MIN_PULSE - 1);
    check("R10 short pulse flagged", 82'(short_pulse), 82'd1);
    read_row(7, '0, "R10 short pulse stores nothing");
    check("R10 read keeps flag", 82'(short_pulse), 82'd1);
    write_row(7, pb, MIN_PULSE);
    check("R10 exact minimum clears flag", 82'(short_pulse), 82'd0);
    read_row(7, pb, "R10 exact minimum stores");

    // R8 security
    write_row(61, 82'd1, MIN_PULSE);
    read_row(61, 82'd1, "R8 security readback");
    read_row(3, '0, "R8 fuse row hidden");
    read_row(32, ps, "R8 signature still readable");
    read_row(60, pc, "R8 ctrl still readable");

    // R9 bulk erase
    write_row(63, '0, MIN_PULSE);
    read_row(61, '0, "R9 security cleared");
    read_row(3, '0, "R9 fuse row 3 erased");
    read_row(7, '0, "R9 fuse row 7 erased");
    read_row(32, '0, "R9 signature erased");
    read_row(60, '0, "R9 ctrl erased");
    write_row(3, pb, MIN_PULSE);
    read_row(3, pb, "R9 reprogram after erase");

    wait_clk(4);
    while (act_q.size() > 0) wait_clk(1);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule